// File: doc/BRIEF.md
# PCM Time-Slot Serial Interface

This block connects a parallel voice-sample bus to a serial PCM highway. The highway brings its own bit clock and a frame sync. Each frame, the block sends one sample word into a transmit slot and takes one sample word out of a receive slot. The two slots sit at separate positions, counted in bit clocks from the frame sync. A companded sample is 8 bits and uses one time slot. A linear sample is 16 bits and uses two time slots in a row.

Configuration inputs set the transmit offset, the receive offset, a 2-bit sample format and a global enable. Bits go out most significant first. Each bit is launched on a rising bit-clock edge and captured on a falling edge. The data-out pin is driven only while the block's own transmit bits are on the wire. At every other time the output enable is low, and the pad is expected to float.

Top module: `pcm_slot_port`

## Requirements
- R1: From reset until the first frame sync is detected, `dtx_oe` and `rx_valid` stay 0 and `rx_word` stays 0.
- R2: The rising bit-clock edge at which `fsync` is first seen high after being low is frame position 0. Each later rising edge adds one to the position. Holding `fsync` high for several bit clocks does not restart the count.
- R3: The transmit bits are launched on the rising edges at positions `cfg_tx_start` through `cfg_tx_start`+L-1, one bit per edge, most significant bit first. L is 8 for a companded word and 16 for a linear word. `dtx_oe` is 1 exactly on those bit clocks and 0 on all others.
- R4: Format code 2'b00 (A-law) and code 2'b01 (mu-law) each send `tx_word[7:0]` as 8 bits, and `tx_word[15:8]` has no effect. Code 2'b11 (linear) sends all of `tx_word[15:0]` as 16 bits.
- R5: `tx_word` is sampled at the position-0 edge. A change to `tx_word` later in the frame does not alter the bits sent in that frame.
- R6: `drx` is sampled on the falling edge that follows each rising edge at positions `cfg_rx_start` through `cfg_rx_start`+L-1, most significant bit first. On the falling edge after the last bit, `rx_word` is updated and `rx_valid` goes high for one bit clock. A companded word is presented zero-extended in `rx_word[7:0]`.
- R7: The transmit offset and the receive offset act independently, so either slot may come before, overlap or follow the other.
- R8: While `cfg_enable` is 0, `dtx_oe` stays 0, `rx_valid` stays 0 and `rx_word` keeps its value.
- R9: Format code 2'b10 is reserved and behaves exactly like `cfg_enable` = 0.
- R10: Offsets across the full 10-bit range, up to 1023, place the slots correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Highway bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsync | input | 1 | Frame sync, sampled on rising `bclk` |
| cfg_enable | input | 1 | Global transfer enable |
| cfg_format | input | 2 | Sample format: 00 A-law, 01 mu-law, 10 reserved, 11 linear 16-bit |
| cfg_tx_start | input | 10 | Bit clocks from frame sync to the first transmit bit |
| cfg_rx_start | input | 10 | Bit clocks from frame sync to the first receive bit |
| tx_word | input | 16 | Sample to send; the low byte is used for the companded formats |
| drx | input | 1 | Serial receive data |
| dtx | output | 1 | Serial transmit data, meaningful only while `dtx_oe` is 1 |
| dtx_oe | output | 1 | Transmit pad drive enable; 0 means high impedance |
| rx_word | output | 16 | Last received sample |
| rx_valid | output | 1 | One-bit-clock strobe marking a new `rx_word` |

## Verification
Each frame is run for the full length that the largest offset needs, and both pins are compared on every bit clock. This catches a slot that is shifted by one position, that is one bit too short or too long, or that fires again outside its window.

A table of frames mixes all three working format codes with transmit and receive offsets that come before, overlap or follow each other. This separates slot placement from word length, and shows that the two directions do not interfere. The high byte of the transmit word is set to junk in the companded entries, and the word is inverted right after frame sync. A design that sends the wrong byte or reads the word late is caught. The receive pin carries a toggling filler outside the window, so a capture window that is one bit off gives a wrong word.

Directed frames cover several more cases: a frame sync held high for several clocks, a disabled frame, the reserved format code, and offsets near 1023.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;

  typedef enum logic [1:0] {
    FMT_ALAW  = 2'b00,
    FMT_ULAW  = 2'b01,
    FMT_RSVD  = 2'b10,
    FMT_LIN16 = 2'b11
  } slot_fmt_e;

  // transfers happen only when enabled and the format code is not reserved
  function automatic logic fmt_runs(input logic en, input logic [1:0] fmt);
    return en && (fmt != FMT_RSVD);
  endfunction

  function automatic logic fmt_is_wide(input logic [1:0] fmt);
    return fmt == FMT_LIN16;
  endfunction

  // number of bits on the wire for the selected word size
  function automatic int slot_len(input logic wide, input int narrow_bits, input int wide_bits);
    return wide ? wide_bits : narrow_bits;
  endfunction

  // true when a frame position falls inside a slot
  function automatic logic in_window(input int pos, input int first, input int len);
    return (pos >= first) && (pos < first + len);
  endfunction

  function automatic logic is_last_bit(input int pos, input int first, input int len);
    return pos == first + len - 1;
  endfunction

  // word bit index carried at offset k into a slot, most significant first
  function automatic int msb_index(input int len, input int k);
    return len - 1 - k;
  endfunction

endpackage

// File: rtl/pcm_frame_ctr.sv
module pcm_frame_ctr #(
  parameter int CNT_W = 11
) (
  input  logic             bclk,
  input  logic             rst_n,
  input  logic             fsync,
  output logic             frame_start,
  output logic [CNT_W-1:0] pos_now,
  output logic [CNT_W-1:0] pos_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             fs_q;
  logic [CNT_W-1:0] cnt_q;

  assign frame_start = fsync & ~fs_q;

  // position of the current rising edge; saturates so a lost sync never wraps into a slot
  always_comb begin
    if (frame_start)
      pos_now = '0;
    else if (cnt_q == CNT_MAX)
      pos_now = CNT_MAX;
    else
      pos_now = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q  <= 1'b0;
      cnt_q <= CNT_MAX;
    end else begin
      fs_q  <= fsync;
      cnt_q <= pos_now;
    end
  end

  assign pos_q = cnt_q;

endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot
  import pcm_slot_pkg::*;
#(
  parameter int CNT_W  = 11,
  parameter int OFS_W  = 10,
  parameter int SLOT_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wide,
  input  logic              frame_start,
  input  logic [CNT_W-1:0]  pos_now,
  input  logic [OFS_W-1:0]  tx_start,
  input  logic [WORD_W-1:0] tx_word,
  output logic              tx_hit,
  output logic              dtx,
  output logic              dtx_oe
);

  localparam int IDX_W = $clog2(WORD_W);

  logic [WORD_W-1:0] held_q;
  logic [WORD_W-1:0] src_word;
  logic [IDX_W-1:0]  bit_idx;
  int                len;

  always_comb begin
    len      = slot_len(wide, SLOT_W, WORD_W);
    tx_hit   = run && in_window(int'(pos_now), int'(tx_start), len);
    bit_idx  = IDX_W'(msb_index(len, int'(pos_now) - int'(tx_start)));
    // at position 0 the live word is used so a zero offset still sends the new sample
    src_word = frame_start ? tx_word : held_q;
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      dtx    <= 1'b0;
      dtx_oe <= 1'b0;
    end else begin
      if (frame_start)
        held_q <= tx_word;
      dtx_oe <= tx_hit;
      dtx    <= tx_hit ? src_word[bit_idx] : 1'b0;
    end
  end

endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot
  import pcm_slot_pkg::*;
#(
  parameter int CNT_W  = 11,
  parameter int OFS_W  = 10,
  parameter int SLOT_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wide,
  input  logic [CNT_W-1:0]  pos_q,
  input  logic [OFS_W-1:0]  rx_start,
  input  logic              drx,
  output logic              rx_hit,
  output logic              rx_last,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid
);

  logic [WORD_W-2:0] sh_q;
  logic [WORD_W-1:0] sh_next;
  logic [WORD_W-1:0] narrow_word;
  int                len;

  assign sh_next = {sh_q, drx};

  // companded words are presented zero-extended
  for (genvar b = 0; b < WORD_W; b++) begin : g_narrow
    if (b < SLOT_W) begin : g_keep
      assign narrow_word[b] = sh_next[b];
    end else begin : g_zero
      assign narrow_word[b] = 1'b0;
    end
  end

  always_comb begin
    len     = slot_len(wide, SLOT_W, WORD_W);
    rx_hit  = run && in_window(int'(pos_q), int'(rx_start), len);
    rx_last = rx_hit && is_last_bit(int'(pos_q), int'(rx_start), len);
  end

  // capture on the falling edge, half a bit clock after the launch edge
  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (rx_hit)
        sh_q <= sh_next[WORD_W-2:0];
      rx_valid <= rx_last;
      if (rx_last)
        rx_word <= wide ? sh_next : narrow_word;
    end
  end

endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
  import pcm_slot_pkg::*;
#(
  parameter int OFS_W  = 10,
  parameter int SLOT_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic              cfg_enable,
  input  logic [1:0]        cfg_format,
  input  logic [OFS_W-1:0]  cfg_tx_start,
  input  logic [OFS_W-1:0]  cfg_rx_start,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              drx,
  output logic              dtx,
  output logic              dtx_oe,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid
);

  // one spare bit so the largest offset plus a wide slot never reaches saturation
  localparam int CNT_W = OFS_W + 1;

  logic             run;
  logic             wide;
  logic             frame_start;
  logic [CNT_W-1:0] pos_now;
  logic [CNT_W-1:0] pos_q;
  logic             tx_hit;
  logic             rx_hit;
  logic             rx_last;

  assign run  = fmt_runs(cfg_enable, cfg_format);
  assign wide = fmt_is_wide(cfg_format);

  pcm_frame_ctr #(.CNT_W(CNT_W)) u_ctr (
    .bclk        (bclk),
    .rst_n       (rst_n),
    .fsync       (fsync),
    .frame_start (frame_start),
    .pos_now     (pos_now),
    .pos_q       (pos_q)
  );

  pcm_tx_slot #(
    .CNT_W(CNT_W), .OFS_W(OFS_W), .SLOT_W(SLOT_W), .WORD_W(WORD_W)
  ) u_tx (
    .bclk        (bclk),
    .rst_n       (rst_n),
    .run         (run),
    .wide        (wide),
    .frame_start (frame_start),
    .pos_now     (pos_now),
    .tx_start    (cfg_tx_start),
    .tx_word     (tx_word),
    .tx_hit      (tx_hit),
    .dtx         (dtx),
    .dtx_oe      (dtx_oe)
  );

  pcm_rx_slot #(
    .CNT_W(CNT_W), .OFS_W(OFS_W), .SLOT_W(SLOT_W), .WORD_W(WORD_W)
  ) u_rx (
    .bclk     (bclk),
    .rst_n    (rst_n),
    .run      (run),
    .wide     (wide),
    .pos_q    (pos_q),
    .rx_start (cfg_rx_start),
    .drx      (drx),
    .rx_hit   (rx_hit),
    .rx_last  (rx_last),
    .rx_word  (rx_word),
    .rx_valid (rx_valid)
  );

endmodule

// File: rtl/pcm_slot_port_chk.sv
module pcm_slot_port_chk #(
  parameter int CNT_W = 11,
  parameter int OFS_W = 10
) (
  input logic             bclk,
  input logic             rst_n,
  input logic             cfg_enable,
  input logic [1:0]       cfg_format,
  input logic [OFS_W-1:0] cfg_tx_start,
  input logic             frame_start,
  input logic [CNT_W-1:0] pos_now,
  input logic             dtx_oe,
  input logic             rx_valid
);

  logic [4:0] run_len;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n)
      run_len <= '0;
    else if (dtx_oe)
      run_len <= (run_len == 5'd31) ? run_len : run_len + 5'd1;
    else
      run_len <= '0;
  end

  assert_frame_count_R2: assert property (@(posedge bclk) disable iff (!rst_n)
    frame_start |=> (pos_now == CNT_W'(1)));

  assert_burst_start_R3: assert property (@(posedge bclk) disable iff (!rst_n)
    $rose(dtx_oe) |-> ($past(pos_now) == CNT_W'($past(cfg_tx_start))));

  assert_burst_len_R3: assert property (@(posedge bclk) disable iff (!rst_n)
    run_len <= 5'd16);

  assert_strobe_single_R6: assert property (@(posedge bclk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_quiet_disabled_R8: assert property (@(posedge bclk) disable iff (!rst_n)
    !cfg_enable |=> !dtx_oe);

  assert_quiet_reserved_R9: assert property (@(posedge bclk) disable iff (!rst_n)
    (cfg_format == 2'b10) |=> !dtx_oe);

endmodule

bind pcm_slot_port pcm_slot_port_chk #(.CNT_W(CNT_W), .OFS_W(OFS_W)) u_chk (
  .bclk         (bclk),
  .rst_n        (rst_n),
  .cfg_enable   (cfg_enable),
  .cfg_format   (cfg_format),
  .cfg_tx_start (cfg_tx_start),
  .frame_start  (frame_start),
  .pos_now      (pos_now),
  .dtx_oe       (dtx_oe),
  .rx_valid     (rx_valid)
);

// File: tb/sim_pcm_slot_port.sv
module sim_pcm_slot_port;

  logic        bclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fsync = 1'b0;
  logic        cfg_enable = 1'b1;
  logic [1:0]  cfg_format = 2'b11;
  logic [9:0]  cfg_tx_start = '0;
  logic [9:0]  cfg_rx_start = '0;
  logic [15:0] tx_word = '0;
  logic        drx = 1'b0;
  logic        dtx;
  logic        dtx_oe;
  logic [15:0] rx_word;
  logic        rx_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // every frame runs this many positions, past the largest slot end
  localparam int FRAME_LEN = 1060;

  // {format, tx offset, rx offset, tx word, rx word}; R4 and R7 are covered by these
  localparam logic [53:0] VEC [6] = '{
    {2'b00, 10'd0,  10'd0,  16'h00A5, 16'h003C},
    {2'b01, 10'd3,  10'd9,  16'h12C3, 16'h0096},
    {2'b11, 10'd1,  10'd4,  16'hB1E7, 16'h8E31},
    {2'b11, 10'd20, 10'd2,  16'h7F01, 16'h4002},
    {2'b00, 10'd17, 10'd17, 16'hFF80, 16'h0081},
    {2'b01, 10'd9,  10'd0,  16'hA55A, 16'h00FF}
  };

  always #4 bclk = ~bclk;

  pcm_slot_port u0 (
    .bclk         (bclk),
    .rst_n        (rst_n),
    .fsync        (fsync),
    .cfg_enable   (cfg_enable),
    .cfg_format   (cfg_format),
    .cfg_tx_start (cfg_tx_start),
    .cfg_rx_start (cfg_rx_start),
    .tx_word      (tx_word),
    .drx          (drx),
    .dtx          (dtx),
    .dtx_oe       (dtx_oe),
    .rx_word      (rx_word),
    .rx_valid     (rx_valid)
  );

  task automatic chk(input string req, input string ctx, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, ctx, act, exp);
    end
  endtask

  task automatic run_frame(input logic en, input logic [1:0] fmt, input int txs, input int rxs,
                           input logic [15:0] txw, input logic [15:0] rxw, input int hold,
                           input string ctx);
    int   len;
    bit   act;
    bit   exp_oe;
    bit   exp_v;
    logic [15:0] prev_rx;
    logic [15:0] exp_word;
    len = (fmt == 2'b11) ? 16 : 8;
    act = en && (fmt != 2'b10);
    exp_word = (len == 16) ? rxw : {8'h00, rxw[7:0]};
    @(posedge bclk); #1;
    cfg_enable = en; cfg_format = fmt;
    cfg_tx_start = 10'(txs); cfg_rx_start = 10'(rxs);
    fsync = 1'b0;
    @(posedge bclk); #1;
    fsync = 1'b1; tx_word = txw;
    prev_rx = rx_word;
    for (int p = 0; p < FRAME_LEN; p++) begin
      @(posedge bclk); #1;
      fsync = (p + 1 < hold);
      tx_word = ~txw;
      if (p >= rxs && p < rxs + len) drx = rxw[len - 1 - (p - rxs)];
      else drx = p[0] ^ p[2];
      #1;
      exp_oe = act && (p >= txs) && (p < txs + len);
      chk("R3", ctx, int'(dtx_oe), int'(exp_oe));
      if (exp_oe) chk("R4 R5", ctx, int'(dtx), int'(txw[len - 1 - (p - txs)]));
      exp_v = act && (p == rxs + len);
      chk("R6", ctx, int'(rx_valid), int'(exp_v));
      if (exp_v) chk("R6", ctx, int'(rx_word), int'(exp_word));
    end
    if (!act) chk("R8", ctx, int'(rx_word), int'(prev_rx));
  endtask

  initial begin
    repeat (150000) @(posedge bclk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge bclk);
    #1 rst_n = 1'b1;
    // R1: quiet after reset and before any frame sync
    for (int i = 0; i < 6; i++) begin
      @(posedge bclk); #2;
      chk("R1", "dtx_oe", int'(dtx_oe), 0);
      chk("R1", "rx_valid", int'(rx_valid), 0);
      chk("R1", "rx_word", int'(rx_word), 0);
    end

    for (int v = 0; v < 6; v++) begin
      run_frame(1'b1, VEC[v][53:52], int'(VEC[v][51:42]), int'(VEC[v][41:32]),
                VEC[v][31:16], VEC[v][15:0], 1, $sformatf("vec%0d", v));
    end

    // R2: sync held high for four clocks keeps counting from the first edge
    run_frame(1'b1, 2'b11, 2, 5, 16'hC00F, 16'h5AA5, 4, "R2 long sync");
    // R8: disabled frame
    run_frame(1'b0, 2'b11, 0, 0, 16'hFFFF, 16'h1234, 1, "R8 disabled");
    // R9: reserved format code
    run_frame(1'b1, 2'b10, 3, 3, 16'hFFFF, 16'h00F0, 1, "R9 reserved");
    // R10: offsets near the top of the range, also recovery after the quiet frames
    run_frame(1'b1, 2'b11, 1000, 1023, 16'h8001, 16'hE00D, 1, "R10 far wide");
    run_frame(1'b1, 2'b00, 1023, 1000, 16'h0081, 16'h0066, 1, "R10 far narrow");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule